// File: doc/BRIEF.md
# Cascadable serial configuration store

This block is a read-only, one-bit-wide store that a configuration loader reads one bit per clock. An internal address counter selects the bit that is presented. While the store is enabled, each rising clock edge moves the counter on by one, so the bits come out in address order. The contents are fixed when the block is elaborated. Bit `a` is the XOR reduction of the address ANDed with the parameter `PATTERN_MASK`.

A single pin serves as both reset and output enable. The parameter `RST_ACTIVE_HIGH` sets its polarity. When reset is asserted, the counter clears and the output floats. The chip enable `ce_n` is active low. When it is high, the counter freezes, the output floats and `standby` is raised. A `busy` input holds the current bit in place.

After the last bit has been shown, one more enabled edge releases the data line and pulls `ceo_n` low. `ceo_n` drives the chip enable of the next store, so a chain of stores reads out as one continuous stream. The pin `data_o` is a tri-state output. `data_oe` and `data_val` report the same output as plain signals that can be checked directly.

Top module: `cfg_serial_store`

## Requirements
- R1: At a rising edge with reset asserted, the counter returns to address 0 and the end flag clears. While reset is asserted, `data_oe` is 0 and `ceo_n` is 1.
- R2: With `RST_ACTIVE_HIGH`=1, `rst_oe`=1 means reset. With `RST_ACTIVE_HIGH`=0, `rst_oe`=0 means reset. The other level of the pin means outputs enabled.
- R3: The counter advances by one at each rising edge on which all of these hold: reset is not asserted, `ce_n` is 0, `busy` is 0 and the end has not been reached.
- R4: While `ce_n`=1, the counter is frozen, `data_oe`=0 and `standby`=1. When `ce_n`=0, `standby`=0.
- R5: While `busy`=1, the counter and the end flag hold, so the bit on the output does not change.
- R6: While `data_oe`=1, `data_val` equals stored bit `a`, where `a` is the counter value. Bit `a` is defined as ^(a & PATTERN_MASK). `data_o` carries the same bit and is high impedance when `data_oe`=0, in which case `data_val`=0.
- R7: Address DEPTH-1 is the last address. An enabled edge taken at the last address sets the end flag. From then on `data_oe`=0 until the next reset.
- R8: While the end flag is set and reset is not asserted, `ceo_n` equals `ce_n`. In every other case `ceo_n`=1.
- R9: Reset has priority over `ce_n` and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; the counter moves on rising edges |
| rst_oe | input | 1 | Combined reset / output enable; polarity set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Chip enable, active low |
| busy | input | 1 | Holds the output bit and the counter while high |
| data_o | output | 1 | Tri-state serial data |
| data_oe | output | 1 | High when `data_o` is driven |
| data_val | output | 1 | Driven bit value, 0 when not driven |
| ceo_n | output | 1 | Chip enable for the next store in a chain, active low |
| standby | output | 1 | High while the store is deselected |

## Verification
Two stores are chained: the first uses an active-high reset and the second an active-low reset. The second store's chip enable is the first store's `ceo_n`, so the handoff and both reset polarities are checked in the same run. A directed pass with no interruptions reads the whole chain. It shows that the end of the first store hands over cleanly, without a missing or repeated bit. Random reset, chip-enable and busy patterns then arrive in the middle of a readout. These show which condition blocks the counter, and that reset overrides busy and deselection. A final directed case deselects the chain after the end has been reached, which separates `ceo_n` following `ce_n` from `ceo_n` being held high.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

   // Stored bit at address a: parity of the address bits selected by mask.
   function automatic logic content_bit(input logic [31:0] a, input logic [31:0] mask);
      return ^(a & mask);
   endfunction

endpackage

// File: rtl/cfg_store_rom.sv
module cfg_store_rom #(
   parameter int unsigned      DEPTH        = 256,
   parameter logic [31:0]      PATTERN_MASK = 32'h0000_00B7,
   localparam int unsigned     AW           = $clog2(DEPTH)
) (
   input  logic [AW-1:0] addr,
   output logic          bit_o
);
   import cfg_store_pkg::*;

   logic [DEPTH-1:0] rom;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      assign rom[i] = content_bit(32'(i), PATTERN_MASK);
   end

   assign bit_o = rom[addr];
endmodule

// File: rtl/cfg_store_ctr.sv
module cfg_store_ctr #(
   parameter int unsigned  DEPTH = 256,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
   input  logic          clk,
   input  logic          rst_act,
   input  logic          ce_n,
   input  logic          busy,
   output logic [AW-1:0] addr,
   output logic          done
);
   logic adv;
   assign adv = !ce_n && !busy && !done;

   always_ff @(posedge clk) begin
      if (rst_act) begin
         addr <= '0;
         done <= 1'b0;
      end else if (adv) begin
         if (addr == LAST) done <= 1'b1;
         else              addr <= addr + 1'b1;
      end
   end

   // R1 / R9: reset wins over every other input
   p_reset_clears_r1: assert property (@(posedge clk)
      rst_act |=> (addr == '0) && !done);

   // R4: deselected store keeps its address
   p_ce_freeze_r4: assert property (@(posedge clk) disable iff (rst_act)
      ce_n |=> $stable(addr));

   // R5: busy holds position and end flag
   p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst_act)
      busy |=> $stable(addr) && $stable(done));

   // R7: end flag is sticky until reset
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst_act)
      done |=> done);

   // R7: counter never runs past the last address
   p_addr_bound_r7: assert property (@(posedge clk) disable iff (rst_act)
      addr <= LAST);
endmodule

// File: rtl/cfg_serial_store.sv
module cfg_serial_store #(
   parameter int unsigned  DEPTH           = 256,
   parameter bit           RST_ACTIVE_HIGH = 1'b0,
   parameter logic [31:0]  PATTERN_MASK    = 32'h0000_00B7,
   localparam int unsigned AW              = $clog2(DEPTH)
) (
   input  logic clk,
   input  logic rst_oe,
   input  logic ce_n,
   input  logic busy,
   output tri   data_o,
   output logic data_oe,
   output logic data_val,
   output logic ceo_n,
   output logic standby
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic rst_act;
   if (RST_ACTIVE_HIGH) begin : g_rst_hi
      assign rst_act = rst_oe;
   end else begin : g_rst_lo
      assign rst_act = !rst_oe;
   end

   logic [AW-1:0] addr;
   logic          done;
   logic          cur_bit;

   cfg_store_ctr #(.DEPTH(DEPTH)) u_ctr (
      .clk     (clk),
      .rst_act (rst_act),
      .ce_n    (ce_n),
      .busy    (busy),
      .addr    (addr),
      .done    (done)
   );

   cfg_store_rom #(.DEPTH(DEPTH), .PATTERN_MASK(PATTERN_MASK)) u_rom (
      .addr  (addr),
      .bit_o (cur_bit)
   );

   assign data_oe  = !rst_act && !ce_n && !done;
   assign data_val = data_oe && cur_bit;
   assign data_o   = data_oe ? cur_bit : 1'bz;
   assign ceo_n    = (done && !rst_act) ? ce_n : 1'b1;
   assign standby  = ce_n;

   // R8: a store that hands over never drives data at the same time
   p_handoff_exclusive_r8: assert property (@(posedge clk) disable iff (rst_act)
      !ceo_n |-> !data_oe);

   // R1: reset releases the data line and the chain enable
   p_reset_outputs_r1: assert property (@(posedge clk)
      rst_act |-> !data_oe && ceo_n);
endmodule

// File: tb/cfg_serial_store_tb.sv
module cfg_serial_store_tb;
   localparam int unsigned D1 = 24;
   localparam int unsigned D2 = 16;
   localparam logic [31:0] M1 = 32'h0000_00B7;
   localparam logic [31:0] M2 = 32'h0000_000D;

   logic clk = 1'b0;
   always #10 clk = !clk;

   logic rst = 1'b1;           // logical reset, mapped to each pin polarity
   logic ce_n = 1'b1, busy = 1'b0;
   tri   d1_o, d2_o;
   logic d1_oe, d1_val, ceo1_n, sb1;
   logic d2_oe, d2_val, ceo2_n, sb2;

   cfg_serial_store #(.DEPTH(D1), .RST_ACTIVE_HIGH(1'b1), .PATTERN_MASK(M1)) u_dut (
      .clk(clk), .rst_oe(rst), .ce_n(ce_n), .busy(busy),
      .data_o(d1_o), .data_oe(d1_oe), .data_val(d1_val), .ceo_n(ceo1_n), .standby(sb1));

   cfg_serial_store #(.DEPTH(D2), .RST_ACTIVE_HIGH(1'b0), .PATTERN_MASK(M2)) u_dut2 (
      .clk(clk), .rst_oe(!rst), .ce_n(ceo1_n), .busy(busy),
      .data_o(d2_o), .data_oe(d2_oe), .data_val(d2_val), .ceo_n(ceo2_n), .standby(sb2));

   int vectors = 0, errors = 0;
   int a1 = 0, a2 = 0;
   bit f1 = 0, f2 = 0;
   int stream_bits = 0;

   function automatic logic exp_bit(int a, logic [31:0] m);
      logic p = 1'b0;
      for (int i = 0; i < 32; i++) if (a[i] && m[i]) p = !p;
      return p;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic cyc(logic r, logic c, logic b);
      logic e_oe1, e_ceo1, e_oe2, e_ceo2;
      rst = r; ce_n = c; busy = b;
      #1;
      e_oe1  = !r && !c && !f1;
      e_ceo1 = (f1 && !r) ? c : 1'b1;
      e_oe2  = !r && !e_ceo1 && !f2;
      e_ceo2 = (f2 && !r) ? e_ceo1 : 1'b1;
      chk("R4 standby", sb1, c);
      chk("R4/R7/R9 data_oe store1", d1_oe, e_oe1);
      chk("R6 data store1", d1_val, e_oe1 ? exp_bit(a1, M1) : 1'b0);
      chk("R8 ceo store1", ceo1_n, e_ceo1);
      chk("R2 data_oe store2 (low reset)", d2_oe, e_oe2);
      chk("R6 data store2", d2_val, e_oe2 ? exp_bit(a2, M2) : 1'b0);
      chk("R8 ceo store2", ceo2_n, e_ceo2);
      if (e_oe1 || e_oe2) stream_bits++;
      @(posedge clk);
      // R3 / R5 / R7 / R9 reference update
      if (r) begin
         a1 = 0; f1 = 0; a2 = 0; f2 = 0;
      end else begin
         if (!c && !b && !f1) begin
            if (a1 == D1 - 1) f1 = 1; else a1++;
         end
         if (!e_ceo1 && !b && !f2) begin
            if (a2 == D2 - 1) f2 = 1; else a2++;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      // R1 / R2: reset state, with chip enabled and busy (R9)
      cyc(1, 0, 1);
      cyc(1, 0, 0);
      // R3 / R6 / R7: uninterrupted read of the whole chain
      stream_bits = 0;
      for (int i = 0; i < D1 + D2 + 4; i++) cyc(0, 0, 0);
      chk("R7 continuous stream length", 1'(stream_bits == D1 + D2), 1'b1);
      // R8: after the end, the chain enable follows ce_n
      cyc(0, 1, 0);
      cyc(0, 0, 0);
      // R1: reset after the end restores output
      cyc(1, 1, 0);
      cyc(0, 0, 0);
      // R5: busy hold in the middle
      for (int i = 0; i < 5; i++) cyc(0, 0, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1);
      // R4: deselect in the middle
      for (int i = 0; i < 4; i++) cyc(0, 1, 0);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic r, c, b;
         r = ($urandom_range(0, 99) < 2);
         c = ($urandom_range(0, 99) < 15);
         b = ($urandom_range(0, 99) < 20);
         cyc(r, c, b);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule